// File: doc/BRIEF.md
# Fractional Baud-Rate Generator

This block turns a peripheral clock into a one-cycle baud tick for a serial channel. Three stages do the work in order. A free-running power-of-two prescaler produces an enable pulse. An optional phase-accumulator divider can then pass only a fraction STEP/256 of those pulses. Last, an 8-bit down-counter with a programmable reload value emits one tick every reload+1 counting events.

The block has two divider modes. In fractional mode the run bit starts and stops the baud counter. In normal-divider mode the accumulator keeps running and raising its overflow flag, but the baud counter is held and the run bit is ignored. The tick rate is f_clk / 2^N × (STEP/256, only when the divider is on in fractional mode) / (reload+1).

Top module: `uart_baud_gen`

## Requirements
- R1: After reset, baud_tick_o and frac_ovf_o are 0. The baud counter and the accumulator are cleared, so the first counting event after reset causes an underflow.
- R2: The prescaler emits one enable pulse every 2^N clock cycles, where N is presc_sel_i (0..7). N=0 gives a pulse on every cycle and N=7 gives one every 128 cycles.
- R3: The baud counter decrements on each counting event. At an event where it is 0, it reloads from reload_i and baud_tick_o goes high for exactly one cycle, in the cycle after that event. Ticks are therefore reload_i+1 events apart.
- R4: When frac_en_i=0, the counting events are the prescaler pulses. The tick rate is f_clk/(2^N·(reload+1)), within ±1 tick over a measured window.
- R5: When frac_en_i=1 and frac_mode_i=0, the counting events are the accumulator carries. The tick rate is f_clk·STEP/(256·2^N·(reload+1)), within ±1 tick. STEP=0 gives no ticks.
- R6: When frac_en_i=1 and frac_mode_i=1, the baud counter is held and no tick is produced, whatever the value of run_i.
- R7: When run_i=0, the counter freezes at its current value without reloading and no tick is produced. Setting run_i back to 1 resumes the count from the frozen value.
- R8: A new reload_i value takes effect only at the next underflow. The period that is already running finishes with the old value.
- R9: frac_ovf_o goes to 1 in the cycle after any accumulator carry, in either divider mode. It is cleared by holding ovf_clr_i=1 for a cycle. A carry in the same cycle takes priority over the clear.
- R10: When frac_en_i=0, the accumulator holds its value and produces no carries, so frac_ovf_o stays at 0 once cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Baud counter run enable |
| presc_sel_i | input | 3 | Prescale exponent N, divide by 2^N |
| frac_en_i | input | 1 | Fractional divider enable |
| frac_mode_i | input | 1 | 0 = fractional mode, 1 = normal-divider mode |
| step_i | input | 8 | Accumulator increment STEP |
| reload_i | input | 8 | Baud counter reload value |
| ovf_clr_i | input | 1 | Write-one clear for the overflow flag |
| baud_tick_o | output | 1 | One-cycle baud tick |
| frac_ovf_o | output | 1 | Sticky accumulator overflow flag |

## Verification
The assertions check cycle-level rules on every clock. They cover prescaler pulse spacing, counter freezing when no event arrives, reload capture at each tick, the flag being set after a carry, and the absence of ticks in normal-divider mode or while stopped. Average tick rates across prescale, STEP and reload settings can only be shown by the bench's windowed tick counts. The same holds for resume-from-frozen timing and for a reload change applying only after the running period.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned ACC_W  = 8;
  localparam int unsigned TMR_W  = 8;
  localparam int unsigned PCNT_W = (1 << SEL_W) - 1;

  typedef enum logic {
    SRC_PRESC = 1'b0,
    SRC_FRAC  = 1'b1
  } evt_src_e;
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_pkg::*;
#(
  parameter int unsigned SW = SEL_W,
  localparam int unsigned CW = (1 << SW) - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] sel_i,
  output logic          tick_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] mask;

  for (genvar i = 0; i < CW; i++) begin : g_mask
    assign mask[i] = (SW'(i) < sel_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = &(cnt_q | ~mask);

  assert_presc_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i != '0) |=> (!tick_o || sel_i != $past(sel_i)));
endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div
  import baud_pkg::*;
#(
  parameter int unsigned AW = ACC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [AW-1:0] step_i,
  output logic          carry_o
);
  logic [AW-1:0] acc_q;
  logic [AW:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, step_i};
  assign carry_o = en_i & tick_i & sum[AW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            acc_q <= '0;
    else if (en_i && tick_i) acc_q <= sum[AW-1:0];
  end

  assert_acc_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q));
endmodule

// File: rtl/baud_timer.sv
module baud_timer
  import baud_pkg::*;
#(
  parameter int unsigned TW = TMR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_i,
  input  logic [TW-1:0] reload_i,
  output logic          tick_o
);
  logic [TW-1:0] cnt_q;
  logic          tick_q;
  logic          under;

  assign under = evt_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= under;
      if (under)      cnt_q <= reload_i;
      else if (evt_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick_o = tick_q;

  assert_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> $stable(cnt_q));
  assert_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (cnt_q == $past(reload_i)));
  assert_decrement_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1) && !tick_o);
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import baud_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] presc_sel_i,
  input  logic             frac_en_i,
  input  logic             frac_mode_i,
  input  logic [ACC_W-1:0] step_i,
  input  logic [TMR_W-1:0] reload_i,
  input  logic             ovf_clr_i,
  output logic             baud_tick_o,
  output logic             frac_ovf_o
);
  logic     presc_tick;
  logic     frac_carry;
  logic     tmr_evt;
  logic     tmr_run;
  logic     ovf_q;
  evt_src_e src;

  baud_prescaler #(.SW(SEL_W)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (presc_sel_i),
    .tick_o(presc_tick)
  );

  baud_frac_div #(.AW(ACC_W)) u_frac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (frac_en_i),
    .tick_i (presc_tick),
    .step_i (step_i),
    .carry_o(frac_carry)
  );

  // normal-divider mode parks the timer and overrides run
  assign src     = frac_en_i ? SRC_FRAC : SRC_PRESC;
  assign tmr_run = run_i && !(frac_en_i && frac_mode_i);
  assign tmr_evt = tmr_run && ((src == SRC_FRAC) ? frac_carry : presc_tick);

  baud_timer #(.TW(TMR_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (tmr_evt),
    .reload_i(reload_i),
    .tick_o  (baud_tick_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ovf_q <= 1'b0;
    else if (frac_carry) ovf_q <= 1'b1;
    else if (ovf_clr_i)  ovf_q <= 1'b0;
  end

  assign frac_ovf_o = ovf_q;

  assert_ovf_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frac_carry |=> frac_ovf_o);
  assert_no_carry_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frac_en_i && !frac_ovf_o && ovf_clr_i) |=> !frac_ovf_o);
  assert_nd_mode_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frac_en_i && frac_mode_i) |=> !baud_tick_o);
  assert_stopped_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !baud_tick_o);
  assert_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frac_en_i && run_i && !presc_tick) |=> !baud_tick_o);
endmodule

// File: tb/tb_uart_baud_gen.sv
module tb_uart_baud_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b0;
  logic [2:0] presc_sel_i = '0;
  logic       frac_en_i = 1'b0;
  logic       frac_mode_i = 1'b0;
  logic [7:0] step_i = '0;
  logic [7:0] reload_i = '0;
  logic       ovf_clr_i = 1'b0;
  logic       baud_tick_o;
  logic       frac_ovf_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  uart_baud_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .presc_sel_i(presc_sel_i),
    .frac_en_i(frac_en_i), .frac_mode_i(frac_mode_i), .step_i(step_i),
    .reload_i(reload_i), .ovf_clr_i(ovf_clr_i),
    .baud_tick_o(baud_tick_o), .frac_ovf_o(frac_ovf_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_reset(input bit run, input int sel, input bit fen, input bit fmode,
                          input int step, input int rel);
    @(negedge clk_i);
    rst_ni      = 1'b0;
    run_i       = run;
    presc_sel_i = 3'(sel);
    frac_en_i   = fen;
    frac_mode_i = fmode;
    step_i      = 8'(step);
    reload_i    = 8'(rel);
    ovf_clr_i   = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic count_ticks(input int win, output int c);
    c = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk_i);
      if (baud_tick_o) c++;
    end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!baud_tick_o && n < 1000);
  endtask

  // windowed rate check against f*step/(256*2^N*(R+1)), +-1 tick
  task automatic rate_case(input int sel, input bit fen, input int step, input int rel,
                           input int win, input string req);
    int c;
    longint num, den;
    do_reset(1'b1, sel, fen, 1'b0, step, rel);
    count_ticks(win, c);
    num = longint'(win) * (fen ? step : 256);
    den = longint'(256) * (longint'(1) << sel) * (rel + 1);
    chk((c * den >= num - den) && (c * den <= num + den), req, c, num / den);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #1;
    chk(baud_tick_o == 1'b0, "R1 tick at reset", baud_tick_o, 0);
    chk(frac_ovf_o == 1'b0, "R1 ovf at reset", frac_ovf_o, 0);
    // counter cleared: first event underflows, tick visible at first negedge
    do_reset(1'b1, 0, 1'b0, 1'b0, 0, 9);
    @(negedge clk_i);
    chk(baud_tick_o == 1'b1, "R1 first event underflows", baud_tick_o, 1);
    @(negedge clk_i);
    chk(baud_tick_o == 1'b0, "R3 tick lasts one cycle", baud_tick_o, 0);
  endtask

  task automatic t_period();
    int n;
    do_reset(1'b1, 0, 1'b0, 1'b0, 0, 3);
    wait_tick(n);
    wait_tick(n);
    chk(n == 4, "R3 period reload+1", n, 4);
    do_reset(1'b1, 2, 1'b0, 1'b0, 0, 0);
    wait_tick(n);
    wait_tick(n);
    chk(n == 4, "R2 divide by 4 spacing", n, 4);
  endtask

  task automatic t_rates();
    rate_case(0, 1'b0, 0, 9, 2000, "R4 sel0 rel9");
    rate_case(3, 1'b0, 0, 4, 4000, "R4 sel3 rel4");
    rate_case(7, 1'b0, 0, 1, 25600, "R2 sel7 rel1");
    rate_case(0, 1'b1, 64, 2, 3072, "R5 step64 rel2");
    rate_case(2, 1'b1, 200, 0, 25600, "R5 step200 sel2");
    rate_case(1, 1'b1, 1, 0, 20480, "R5 step1 sel1");
    rate_case(0, 1'b1, 0, 0, 1000, "R5 step0 no ticks");
  endtask

  task automatic t_normal_mode();
    int c;
    do_reset(1'b1, 0, 1'b1, 1'b1, 128, 0);
    count_ticks(1000, c);
    chk(c == 0, "R6 normal mode no ticks", c, 0);
    chk(frac_ovf_o == 1'b1, "R9 ovf set in normal mode", frac_ovf_o, 1);
    // R9 clear, then R10 no carries with divider off
    frac_en_i = 1'b0;
    ovf_clr_i = 1'b1;
    @(negedge clk_i);
    ovf_clr_i = 1'b0;
    chk(frac_ovf_o == 1'b0, "R9 write-one clear", frac_ovf_o, 0);
    run_i = 1'b0;
    repeat (50) @(negedge clk_i);
    chk(frac_ovf_o == 1'b0, "R10 no carry when disabled", frac_ovf_o, 1'b0);
  endtask

  task automatic t_stop();
    int c, n;
    do_reset(1'b0, 0, 1'b0, 1'b0, 0, 0);
    count_ticks(200, c);
    chk(c == 0, "R7 run low no ticks", c, 0);
    do_reset(1'b1, 0, 1'b0, 1'b0, 0, 5);
    wait_tick(n);
    repeat (2) @(negedge clk_i);
    run_i = 1'b0;
    count_ticks(10, c);
    chk(c == 0, "R7 frozen no ticks", c, 0);
    run_i = 1'b1;
    wait_tick(n);
    chk(n == 4, "R7 resume from frozen value", n, 4);
  endtask

  task automatic t_reload_change();
    int n;
    do_reset(1'b1, 0, 1'b0, 1'b0, 0, 5);
    wait_tick(n);
    reload_i = 8'd2;
    wait_tick(n);
    chk(n == 6, "R8 old period completes", n, 6);
    wait_tick(n);
    chk(n == 3, "R8 new reload applied", n, 3);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    t_reset();
    t_period();
    t_rates();
    t_normal_mode();
    t_stop();
    t_reload_change();
    finish_run();
  end
endmodule